// File: doc/BRIEF.md
# Burst-Driven Island Clock Mode Controller

This controller sits in the wrapper around a locally synchronous island and decides where the island's clock pulses come from. While a burst of input transfers is arriving over a four-phase request/acknowledge port, every accepted request yields one island clock pulse, so the data source sets the pace. When the requests stop, an inactivity timer runs out. The controller then drains the island pipeline with a fixed number of pulses taken from the local clock source, and after that it keeps the island running on local pulses. A new request pulls it back to burst-driven operation. An external stop input parks the island with no pulses at all.

The island clock is modelled as a one-cycle enable pulse on a fast sampling clock, together with a source select. The local clock source is a one-cycle tick input. All outputs come straight from registers, so no control output glitches.

Top module: `gwc_mode_ctrl`

## Requirements
- R1: After reset, mode_o is 0 (idle), in_ack_o is 0 and isl_clk_en_o is 0.
- R2: in_ack_o rises in the cycle after a request is accepted, and only while in_req_i was high. It falls in the cycle after in_req_i is seen low. A request is accepted only while in_ack_o is low.
- R3: Each accepted request produces exactly one isl_clk_en_o pulse, in the following cycle, with isl_clk_sel_o = 0 (request source). In that same cycle in_data_o holds the data sampled with the request.
- R4: Mode encoding is 0 idle, 1 request-driven, 2 flush, 3 local. In mode 1, if no request is accepted for TIMEOUT+1 cycles after the accepting edge, mode_o becomes 2. Every accepted request restarts that count.
- R5: In mode 2 each loc_tick_i gives one isl_clk_en_o pulse with isl_clk_sel_o = 1. Exactly DEPTH such pulses are issued, and mode_o becomes 3 with the last one.
- R6: No request is acknowledged in mode 2. A pending request waits until mode 3.
- R7: In mode 3 every loc_tick_i gives one isl_clk_en_o pulse with isl_clk_sel_o = 1. Cycles without a tick give no pulse.
- R8: In mode 3 a pending request is accepted in the first cycle with no loc_tick_i, and the mode returns to 1. A tick in the same cycle is served first as a local pulse.
- R9: stop_i high forces mode 0 at the next edge. While stop_i is high no pulse is issued and no request is accepted. In mode 0 local ticks give no pulse.
- R10: In mode 0 with stop_i low, a request is accepted and the mode becomes 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stop_i | input | 1 | Forces idle, suppresses pulses |
| in_req_i | input | 1 | Four-phase input request |
| in_data_i | input | DATA_W | Input data, valid with request |
| in_ack_o | output | 1 | Four-phase input acknowledge |
| in_data_o | output | DATA_W | Data captured at acceptance |
| loc_tick_i | input | 1 | One-cycle pulse from local clock source |
| isl_clk_en_o | output | 1 | Island clock pulse |
| isl_clk_sel_o | output | 1 | Source of last pulse: 0 request, 1 local |
| mode_o | output | 2 | Current mode |

## Verification
The assertions assume that the environment obeys the four-phase rules. A request stays high until it is acknowledged and stays low until the acknowledge has dropped. The input data is stable while the request is high. loc_tick_i is a single-cycle strobe. The stimulus raises the request only after it has seen the acknowledge low, and it releases the request only after it has seen the acknowledge high. Ticks, stops and request timing are drawn at random around directed runs through every mode change.

// File: rtl/gwc_pkg.sv
package gwc_pkg;
    typedef enum logic [1:0] {
        MODE_IDLE  = 2'd0,
        MODE_REQ   = 2'd1,
        MODE_FLUSH = 2'd2,
        MODE_LOCAL = 2'd3
    } gw_mode_e;

    typedef struct packed {
        gw_mode_e mode;
        logic     en;
        logic     sel;
    } gw_ctl_s;
endpackage

// File: rtl/gwc_handshake.sv
module gwc_handshake #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              allow_i,
    output logic              accept_o,
    output logic              ack_o,
    output logic [DATA_W-1:0] data_o
);
    typedef struct packed {
        logic              ack;
        logic [DATA_W-1:0] data;
    } hs_s;

    hs_s hs_d, hs_q;

    assign accept_o = req_i & ~hs_q.ack & allow_i;

    always_comb begin
        hs_d = hs_q;
        if (accept_o) begin
            hs_d.ack  = 1'b1;
            hs_d.data = data_i;
        end else if (!req_i) begin
            hs_d.ack = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hs_q <= '0;
        else        hs_q <= hs_d;
    end

    assign ack_o  = hs_q.ack;
    assign data_o = hs_q.data;

    a_r2_ack_rise_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_o) |-> $past(req_i));
    a_r2_ack_fall_needs_release: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack_o) |-> !$past(req_i));
    a_r2_accept_acks: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |=> ack_o);
endmodule

// File: rtl/gwc_timeout.sv
module gwc_timeout #(
    parameter int TIMEOUT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic run_i,
    output logic expired_o
);
    localparam int CW = $clog2(TIMEOUT + 1);
    localparam logic [CW-1:0] LOADV = CW'(TIMEOUT);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)                       cnt_d = LOADV;
        else if (run_i && cnt_q != '0)    cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= LOADV;
        else        cnt_q <= cnt_d;
    end

    assign expired_o = (cnt_q == '0);

    a_r4_reload: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> cnt_q == LOADV);
    a_r4_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LOADV);
endmodule

// File: rtl/gwc_flush.sv
module gwc_flush #(
    parameter int DEPTH = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic tick_i,
    output logic last_o
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] LOADV = CW'(DEPTH);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)                        cnt_d = LOADV;
        else if (tick_i && cnt_q != '0)    cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= LOADV;
        else        cnt_q <= cnt_d;
    end

    assign last_o = (cnt_q == CW'(1));

    a_r5_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LOADV);
    a_r5_load_full: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> cnt_q == LOADV);
endmodule

// File: rtl/gwc_mode_ctrl.sv
module gwc_mode_ctrl
    import gwc_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int TIMEOUT = 16,
    parameter int DEPTH   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stop_i,
    input  logic              in_req_i,
    input  logic [DATA_W-1:0] in_data_i,
    output logic              in_ack_o,
    output logic [DATA_W-1:0] in_data_o,
    input  logic              loc_tick_i,
    output logic              isl_clk_en_o,
    output logic              isl_clk_sel_o,
    output logic [1:0]        mode_o
);
    gw_ctl_s ctl_d, ctl_q;

    logic allow, accept, expired, flush_last, flush_load, flush_tick;

    always_comb begin
        unique case (ctl_q.mode)
            MODE_IDLE, MODE_REQ: allow = !stop_i;
            MODE_LOCAL:          allow = !stop_i && !loc_tick_i;
            default:             allow = 1'b0;
        endcase
    end

    gwc_handshake #(.DATA_W(DATA_W)) u_hs (
        .clk(clk), .rst_n(rst_n), .req_i(in_req_i), .data_i(in_data_i),
        .allow_i(allow), .accept_o(accept), .ack_o(in_ack_o), .data_o(in_data_o)
    );

    gwc_timeout #(.TIMEOUT(TIMEOUT)) u_to (
        .clk(clk), .rst_n(rst_n), .load_i(accept),
        .run_i(ctl_q.mode == MODE_REQ), .expired_o(expired)
    );

    assign flush_tick = (ctl_q.mode == MODE_FLUSH) && loc_tick_i && !stop_i;

    gwc_flush #(.DEPTH(DEPTH)) u_fl (
        .clk(clk), .rst_n(rst_n), .load_i(flush_load),
        .tick_i(flush_tick), .last_o(flush_last)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.en   = 1'b0;
        flush_load = 1'b0;
        if (stop_i) begin
            ctl_d.mode = MODE_IDLE;
        end else if (accept) begin
            ctl_d.mode = MODE_REQ;
            ctl_d.en   = 1'b1;
            ctl_d.sel  = 1'b0;
        end else begin
            unique case (ctl_q.mode)
                MODE_REQ: begin
                    if (expired) begin
                        ctl_d.mode = MODE_FLUSH;
                        flush_load = 1'b1;
                    end
                end
                MODE_FLUSH: begin
                    if (loc_tick_i) begin
                        ctl_d.en  = 1'b1;
                        ctl_d.sel = 1'b1;
                        if (flush_last) ctl_d.mode = MODE_LOCAL;
                    end
                end
                MODE_LOCAL: begin
                    if (loc_tick_i) begin
                        ctl_d.en  = 1'b1;
                        ctl_d.sel = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{mode: MODE_IDLE, en: 1'b0, sel: 1'b0};
        else        ctl_q <= ctl_d;
    end

    assign isl_clk_en_o  = ctl_q.en;
    assign isl_clk_sel_o = ctl_q.sel;
    assign mode_o        = ctl_q.mode;

    a_r3_pulse_per_accept: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> isl_clk_en_o && !isl_clk_sel_o);
    a_r9_stop_idles: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> mode_o == 2'd0 && !isl_clk_en_o);
    a_r7_local_pulse_has_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (isl_clk_en_o && isl_clk_sel_o) |-> $past(loc_tick_i));
    a_r6_no_ack_in_flush: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_ack_o) |-> $past(mode_o) != 2'd2);
    a_r4_flush_from_req: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd2 && $past(mode_o) != 2'd2) |-> $past(mode_o) == 2'd1);
endmodule

// File: tb/sim_gwc_mode_ctrl.sv
module sim_gwc_mode_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 8;
    localparam int TO = 6;
    localparam int DP = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stop_i = 1'b0, in_req_i = 1'b0, loc_tick_i = 1'b0;
    logic [DW-1:0] in_data_i = '0;
    logic in_ack_o, isl_clk_en_o, isl_clk_sel_o;
    logic [DW-1:0] in_data_o;
    logic [1:0] mode_o;

    int checks = 0, errors = 0;
    int m_mode = 0, m_tmr = TO, m_fl = DP;
    logic m_ack = 0, m_en = 0, m_sel = 0;
    logic [DW-1:0] m_data = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gwc_mode_ctrl #(.DATA_W(DW), .TIMEOUT(TO), .DEPTH(DP)) u0 (
        .clk(clk), .rst_n(rst_n), .stop_i(stop_i), .in_req_i(in_req_i),
        .in_data_i(in_data_i), .in_ack_o(in_ack_o), .in_data_o(in_data_o),
        .loc_tick_i(loc_tick_i), .isl_clk_en_o(isl_clk_en_o),
        .isl_clk_sel_o(isl_clk_sel_o), .mode_o(mode_o)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit may_accept(input int md, input logic st, input logic rq,
                                      input logic ak, input logic tk);
        if (st || !rq || ak) return 0;
        return (md == 0 || md == 1 || (md == 3 && !tk));
    endfunction

    task automatic step(input logic rq, input logic [DW-1:0] d, input logic tk, input logic st);
        bit acc;
        int n_mode, n_tmr, n_fl;
        logic n_ack, n_en, n_sel;
        logic [DW-1:0] n_data;
        @(negedge clk);
        in_req_i = rq; in_data_i = d; loc_tick_i = tk; stop_i = st;
        acc = may_accept(m_mode, st, rq, m_ack, tk);
        n_mode = m_mode; n_tmr = m_tmr; n_fl = m_fl;
        n_ack = acc ? 1'b1 : (!rq ? 1'b0 : m_ack);
        n_data = acc ? d : m_data;
        n_en = 0; n_sel = m_sel;
        if (acc) n_tmr = TO;
        else if (m_mode == 1 && m_tmr != 0) n_tmr = m_tmr - 1;
        if (st) n_mode = 0;
        else if (acc) begin n_mode = 1; n_en = 1; n_sel = 0; end
        else if (m_mode == 1 && m_tmr == 0) begin n_mode = 2; n_fl = DP; end
        else if (m_mode == 2 && tk) begin
            n_en = 1; n_sel = 1;
            if (m_fl == 1) n_mode = 3;
            n_fl = m_fl - 1;
        end else if (m_mode == 3 && tk) begin n_en = 1; n_sel = 1; end
        @(posedge clk);
        #1;
        m_mode = n_mode; m_tmr = n_tmr; m_fl = n_fl;
        m_ack = n_ack; m_en = n_en; m_sel = n_sel; m_data = n_data;
        check(mode_o == 2'(m_mode), "R4 mode", mode_o, m_mode);
        check(in_ack_o == m_ack, "R2 ack", in_ack_o, m_ack);
        check(isl_clk_en_o == m_en, "R3 pulse", isl_clk_en_o, m_en);
        check(isl_clk_sel_o == m_sel, "R3 select", isl_clk_sel_o, m_sel);
        if (m_en && !m_sel)
            check(in_data_o == m_data, "R3 data", in_data_o, m_data);
    endtask

    task automatic run_to_local();
        int n = 0;
        step(1, 8'h11, 0, 0);
        while (mode_o != 2'd2 && n < 50) begin step(0, 8'h00, 0, 0); n++; end
        for (int i = 0; i < DP; i++) step(0, 8'h00, 1, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int n, pulses;
        logic rq;
        logic [DW-1:0] dv;
        void'($urandom(32'd12345));
        repeat (3) @(posedge clk);
        #1;
        check(mode_o == 2'd0 && !in_ack_o && !isl_clk_en_o, "R1 reset state", mode_o, 0);
        @(negedge clk); rst_n = 1'b1;

        // R10: accept in idle
        step(1, 8'hA5, 0, 0);
        check(mode_o == 2'd1, "R10 idle accept", mode_o, 1);
        check(isl_clk_en_o && !isl_clk_sel_o && in_data_o == 8'hA5, "R3 first pulse", in_data_o, 8'hA5);
        step(1, 8'hA5, 0, 0);
        step(0, 8'h00, 0, 0);
        check(!in_ack_o, "R2 ack release", in_ack_o, 0);

        // R4: timeout length counted from the accepting edge
        step(1, 8'h3C, 0, 0);
        n = 0;
        while (mode_o != 2'd2 && n < 50) begin step(0, 8'h00, 0, 0); n++; end
        check(n == TO + 1, "R4 timeout length", n, TO + 1);

        // R5/R6: flush pulses while a request waits
        pulses = 0;
        step(1, 8'h77, 0, 0);
        check(!in_ack_o, "R6 held in flush", in_ack_o, 0);
        for (int i = 0; i < DP; i++) begin
            step(1, 8'h77, 1, 0);
            if (isl_clk_en_o && isl_clk_sel_o) pulses++;
            check(!in_ack_o, "R6 no ack in flush", in_ack_o, 0);
        end
        check(pulses == DP, "R5 flush count", pulses, DP);
        check(mode_o == 2'd3, "R5 enter local", mode_o, 3);

        // R8: tick served before pending request
        step(1, 8'h77, 1, 0);
        check(isl_clk_en_o && isl_clk_sel_o && !in_ack_o, "R8 tick first", in_ack_o, 0);
        step(1, 8'h77, 0, 0);
        check(mode_o == 2'd1 && in_ack_o && isl_clk_en_o && !isl_clk_sel_o, "R8 return", mode_o, 1);
        step(0, 8'h00, 0, 0);

        // R7: local pulses follow ticks only
        run_to_local();
        step(0, 8'h00, 0, 0);
        check(mode_o == 2'd3, "R7 in local", mode_o, 3);
        pulses = 0;
        for (int i = 0; i < 4; i++) begin
            step(0, 8'h00, 1, 0);
            if (isl_clk_en_o && isl_clk_sel_o) pulses++;
            step(0, 8'h00, 0, 0);
            check(!isl_clk_en_o, "R7 no tick no pulse", isl_clk_en_o, 0);
        end
        check(pulses == 4, "R7 local pulses", pulses, 4);

        // R9: stop
        step(1, 8'h5A, 1, 1);
        check(mode_o == 2'd0 && !isl_clk_en_o && !in_ack_o, "R9 stop", mode_o, 0);
        step(1, 8'h5A, 1, 1);
        check(!isl_clk_en_o && !in_ack_o, "R9 stop holds", in_ack_o, 0);
        step(0, 8'h00, 1, 0);
        check(!isl_clk_en_o && mode_o == 2'd0, "R9 idle ignores tick", isl_clk_en_o, 0);
        step(1, 8'hC3, 0, 0);
        check(mode_o == 2'd1 && in_ack_o, "R10 after stop", mode_o, 1);

        // random traffic obeying four-phase rules
        rq = 1'b1; dv = 8'hC3;
        for (int i = 0; i < 4000; i++) begin
            logic tk, st;
            tk = ($urandom % 3) == 0;
            st = ($urandom % 97) == 0;
            if (!rq && !in_ack_o && ($urandom % 4) == 0) begin
                rq = 1'b1; dv = 8'($urandom);
            end else if (rq && in_ack_o && ($urandom % 2) == 0) begin
                rq = 1'b0;
            end
            if ((i / 400) % 2 == 1 && !rq) rq = 1'b0;
            step(rq, dv, tk, st);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule